// File: doc/BRIEF.md
# Page Hamming ECC Generator

This block computes a single-error-correcting Hamming check code over flash data while the data streams through it. Bytes arrive one per beat, qualified by a valid strobe. Each accepted byte updates two parity sets. The column parity covers bit positions inside the byte. The line parity covers the byte's index within a 256-byte block. Correcting errors and locating a bad bit are left to the consumer of the codes.

When the 256th byte of a block is accepted, the block latches two results: the 21-bit raw parity and the three-byte stored form of the code. It then raises a one-cycle done flag and restarts accumulation for the next block by itself. A page of N bytes therefore yields N/256 codes of three bytes each. On a 512-byte small page, software places the six code bytes at spare-area offsets 10 to 15. A clear strobe discards a partial block so that accumulation can restart at byte index 0.

Top module: `page_ecc_gen`

## Requirements
- R1: After reset, done_o is 0, raw_o is 0 and all three code byte outputs are 0x00.
- R2: Column parity lives in raw bits 5:0. For bit-index bit k (k = 0..2), raw bit 2k+1 is the XOR of all data bits whose bit position has bit k set. Raw bit 2k is the XOR of all data bits whose bit position has bit k clear.
- R3: Line parity lives in raw bits 20:6 as line bits 14:0. For byte-index bit j (j = 0..6), line bit 2j+1 is the XOR of all bits of the bytes whose index has bit j set. Line bit 2j is the XOR of all bits of the bytes whose index has bit j clear. The byte index counts accepted bytes from 0 within the block.
- R4: Line bit 14 (raw bit 20) is the XOR of all bits of the bytes whose index has bit 7 clear.
- R5: raw_o holds {line[14:0], column[5:0]} for the most recently completed block.
- R6: The stored code C is ~(raw << 2) masked to 24 bits, so bits 1:0 and bit 23 of C are always 1. C is presented with C[23:16] on code_hi_o, C[15:8] on code_mid_o and C[7:0] on code_lo_o.
- R7: done_o is high for exactly one cycle, in the cycle after the clock edge that accepts the 256th byte. raw_o and the code bytes take their new values in that same cycle.
- R8: After a block completes, the next accepted byte is index 0 of a fresh block, even when it arrives in the cycle right after the last byte.
- R9: A cycle with clr_i high zeroes the accumulator and the byte index. clr_i takes priority over valid_i, so a byte presented in the same cycle is discarded. Latched outputs are unchanged.
- R10: Cycles with valid_i low do not change the accumulator or the byte index, whatever data_i holds.
- R11: raw_o and the code bytes hold their values between block completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Discard the partial block and restart at index 0 |
| valid_i | input | 1 | data_i carries a byte this cycle |
| data_i | input | 8 | Data byte |
| raw_o | output | 21 | Raw parity of last block: line above column |
| code_hi_o | output | 8 | Stored code bits 23:16 |
| code_mid_o | output | 8 | Stored code bits 15:8 |
| code_lo_o | output | 8 | Stored code bits 7:0 |
| done_o | output | 1 | One-cycle pulse when a block completes |

## Verification
The byte index and the parity accumulator are hidden, so a fault in either one shows up only at the next block boundary.

- **Byte index faults.** A miscounted index makes done_o arrive early or late against the 256-byte frame. It can also pair parity bits with the wrong index bits, which gives a wrong raw_o once the block ends.
- **Accumulator faults.** A dropped or doubled byte, a clear that fails to clear, or an idle beat that leaks into the parity changes raw_o and the three code bytes. The error is visible in the cycle done_o rises.
- **How the bench finds them.** Single-bit blocks at the first and last index pin down each parity bit. Gapped streams, mid-block clears and back-to-back blocks expose faults in the index and in the clearing.

// File: rtl/page_ecc_pkg.sv
package page_ecc_pkg;
  localparam int unsigned DEF_DATA_W      = 8;
  localparam int unsigned DEF_BLOCK_BYTES = 256;
  localparam int unsigned CODE_W          = 24;
  localparam int unsigned CODE_SHIFT      = 2;
endpackage

// File: rtl/page_ecc_colpar.sv
module page_ecc_colpar #(
  parameter int unsigned DATA_W = page_ecc_pkg::DEF_DATA_W,
  localparam int unsigned BIT_IDX_W = $clog2(DATA_W),
  localparam int unsigned COL_W     = 2 * BIT_IDX_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [COL_W-1:0]  col_par_o,
  output logic              byte_par_o
);
  assign byte_par_o = ^data_i;

  for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_pair
    logic odd_b, even_b;
    always_comb begin
      odd_b  = 1'b0;
      even_b = 1'b0;
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> k) & 1) == 1) odd_b  = odd_b  ^ data_i[b];
        else                     even_b = even_b ^ data_i[b];
      end
    end
    assign col_par_o[2*k+1] = odd_b;
    assign col_par_o[2*k]   = even_b;
  end
endmodule

// File: rtl/page_ecc_accum.sv
module page_ecc_accum #(
  parameter int unsigned DATA_W      = page_ecc_pkg::DEF_DATA_W,
  parameter int unsigned BLOCK_BYTES = page_ecc_pkg::DEF_BLOCK_BYTES,
  localparam int unsigned COL_W  = 2 * $clog2(DATA_W),
  localparam int unsigned IDX_W  = $clog2(BLOCK_BYTES),
  localparam int unsigned LINE_W = 2 * IDX_W - 1,
  localparam int unsigned RAW_W  = LINE_W + COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic [COL_W-1:0] col_par_i,
  input  logic             byte_par_i,
  output logic [RAW_W-1:0] raw_next_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);

  logic [IDX_W-1:0]  cnt_q;
  logic [COL_W-1:0]  col_q, col_n;
  logic [LINE_W-1:0] line_q, line_n;
  logic              take;

  assign take   = valid_i & ~clr_i;
  assign last_o = take & (cnt_q == LAST_IDX);
  assign col_n  = col_q ^ (take ? col_par_i : '0);

  for (genvar j = 0; j < IDX_W - 1; j++) begin : g_line
    assign line_n[2*j+1] = line_q[2*j+1] ^ (take &  cnt_q[j] & byte_par_i);
    assign line_n[2*j]   = line_q[2*j]   ^ (take & ~cnt_q[j] & byte_par_i);
  end
  // top index bit keeps only its even half
  assign line_n[LINE_W-1] = line_q[LINE_W-1] ^ (take & ~cnt_q[IDX_W-1] & byte_par_i);

  assign raw_next_o = {line_n, col_n};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      col_q  <= '0;
      line_q <= '0;
    end else if (clr_i || last_o) begin
      cnt_q  <= '0;
      col_q  <= '0;
      line_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt_q + 1'b1;
      col_q  <= col_n;
      line_q <= line_n;
    end
  end

  assert_clr_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && col_q == '0 && line_q == '0));

  assert_wrap_fresh_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cnt_q == '0 && col_q == '0 && line_q == '0));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> ($stable(cnt_q) && $stable(col_q) && $stable(line_q)));

  assert_index_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/page_ecc_fmt.sv
module page_ecc_fmt #(
  parameter int unsigned RAW_W = 21,
  localparam int unsigned CODE_W = page_ecc_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic [RAW_W-1:0]  raw_i,
  output logic [RAW_W-1:0]  raw_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  logic [CODE_W-1:0] code_n;

  assign code_n = ~(CODE_W'(raw_i) << page_ecc_pkg::CODE_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o  <= '0;
      code_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_i;
      if (last_i) begin
        raw_o  <= raw_i;
        code_o <= code_n;
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> ($stable(raw_o) && $stable(code_o)));
endmodule

// File: rtl/page_ecc_gen.sv
module page_ecc_gen #(
  parameter int unsigned DATA_W      = page_ecc_pkg::DEF_DATA_W,
  parameter int unsigned BLOCK_BYTES = page_ecc_pkg::DEF_BLOCK_BYTES,
  localparam int unsigned COL_W  = 2 * $clog2(DATA_W),
  localparam int unsigned LINE_W = 2 * $clog2(BLOCK_BYTES) - 1,
  localparam int unsigned RAW_W  = LINE_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [RAW_W-1:0]  raw_o,
  output logic [7:0]        code_hi_o,
  output logic [7:0]        code_mid_o,
  output logic [7:0]        code_lo_o,
  output logic              done_o
);
  logic [COL_W-1:0]                col_par;
  logic                            byte_par;
  logic [RAW_W-1:0]                raw_next;
  logic                            last;
  logic [page_ecc_pkg::CODE_W-1:0] code;

  page_ecc_colpar #(.DATA_W(DATA_W)) u_colpar (
    .data_i     (data_i),
    .col_par_o  (col_par),
    .byte_par_o (byte_par)
  );

  page_ecc_accum #(.DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .valid_i    (valid_i),
    .col_par_i  (col_par),
    .byte_par_i (byte_par),
    .raw_next_o (raw_next),
    .last_o     (last)
  );

  page_ecc_fmt #(.RAW_W(RAW_W)) u_fmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_i (last),
    .raw_i  (raw_next),
    .raw_o  (raw_o),
    .code_o (code),
    .done_o (done_o)
  );

  assign code_hi_o  = code[23:16];
  assign code_mid_o = code[15:8];
  assign code_lo_o  = code[7:0];

  assert_code_pad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (code_lo_o[1:0] == 2'b11 && code_hi_o[7]));
endmodule

// File: tb/tb_page_ecc_gen.sv
module tb_page_ecc_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = 8'h00;
  logic [20:0] raw;
  logic [7:0]  c_hi, c_mid, c_lo;
  logic        done;
  int          checks = 0;
  int          errs = 0;

  always #4 clk = ~clk;

  page_ecc_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .valid_i(valid), .data_i(data),
    .raw_o(raw), .code_hi_o(c_hi), .code_mid_o(c_mid), .code_lo_o(c_lo), .done_o(done)
  );

  // stimulus table: mode, seed, idle gaps
  localparam int NVEC = 6;
  localparam int VEC_MODE [NVEC] = '{1, 2, 4, 2, 0, 1};
  localparam int VEC_SEED [NVEC] = '{8'h00, 8'h35, 8'hC3, 8'h9B, 8'h6E, 8'h5A};
  localparam bit VEC_GAPS [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  function automatic logic [7:0] gen_byte(int mode, int seed, int i);
    logic [7:0] ib = i[7:0];
    case (mode)
      0: return seed[7:0];
      1: return ib ^ seed[7:0];
      2: return 8'(i * seed + 59);
      3: return (ib == seed[7:0]) ? (8'h01 << seed[10:8]) : 8'h00;
      default: return {ib[3:0], ib[7:4]} ^ seed[7:0];
    endcase
  endfunction

  function automatic logic [20:0] model(int mode, int seed);
    logic [5:0]  col = '0;
    logic [14:0] line = '0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d = gen_byte(mode, seed, i);
      for (int b = 0; b < 8; b++) begin
        if (d[b]) begin
          for (int k = 0; k < 3; k++)
            if ((b >> k) & 1) col[2*k+1] = ~col[2*k+1]; else col[2*k] = ~col[2*k];
          for (int j = 0; j < 7; j++)
            if ((i >> j) & 1) line[2*j+1] = ~line[2*j+1]; else line[2*j] = ~line[2*j];
          if (((i >> 7) & 1) == 0) line[14] = ~line[14];
        end
      end
    end
    return {line, col};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic stream(int mode, int seed, bit gaps, bit chk_prev, logic [20:0] prev);
    for (int i = 0; i < 256; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        valid = 1'b0;
        data  = ~gen_byte(mode, seed, i) ^ i[7:0];  // R10 garbage on idle beats
      end
      @(negedge clk);
      if (i == 0 && chk_prev) begin
        chk("R8", "done at back-to-back start", 32'(done), 32'd1);
        chk("R8", "raw of previous block", 32'(raw), 32'(prev));
      end
      if (i == 255) chk("R7", "done before last byte", 32'(done), 32'd0);
      valid = 1'b1;
      data  = gen_byte(mode, seed, i);
    end
  endtask

  task automatic finish_block(logic [20:0] exp, string tag);
    logic [23:0] code = ~({3'b000, exp} << 2);
    @(negedge clk);
    valid = 1'b0;
    data  = 8'hFF;
    chk("R7", {tag, " done pulse"}, 32'(done), 32'd1);
    chk("R5", {tag, " raw"}, 32'(raw), 32'(exp));
    chk("R6", {tag, " code bytes"}, {8'h00, c_hi, c_mid, c_lo}, {8'h00, code});
    @(negedge clk);
    chk("R7", {tag, " done low after pulse"}, 32'(done), 32'd0);
    chk("R11", {tag, " raw held"}, 32'(raw), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [20:0] e;
    repeat (3) @(negedge clk);
    chk("R1", "reset done", 32'(done), 32'd0);
    chk("R1", "reset raw", 32'(raw), 32'd0);
    chk("R1", "reset code", {8'h00, c_hi, c_mid, c_lo}, 32'd0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      e = model(VEC_MODE[v], VEC_SEED[v]);
      stream(VEC_MODE[v], VEC_SEED[v], VEC_GAPS[v], 1'b0, '0);
      finish_block(e, $sformatf("vec%0d", v));
    end

    // all zero block: R6 gives all-ones code
    stream(0, 0, 1'b0, 1'b0, '0);
    finish_block(21'h0, "zeros");
    chk("R6", "zero block code", {8'h00, c_hi, c_mid, c_lo}, 32'h00FFFFFF);

    // single bit 0 of byte 0: all even halves set
    stream(3, 0, 1'b0, 1'b0, '0);
    finish_block(21'h155555, "bit0 byte0");
    chk("R2", "even column pairs", 32'(raw[5:0]), 32'h15);
    chk("R4", "line bit14 for index bit7 clear", 32'(raw[20]), 32'd1);
    chk("R3", "even line pairs", 32'(raw[19:6]), 32'h1555);

    // single bit 7 of byte 255: all odd halves set, line bit14 clear
    stream(3, 11'h7FF, 1'b0, 1'b0, '0);
    finish_block(21'h0AAAAA, "bit7 byte255");
    chk("R2", "odd column pairs", 32'(raw[5:0]), 32'h2A);
    chk("R4", "line bit14 for index bit7 set", 32'(raw[20]), 32'd0);
    chk("R6", "code for bit7 byte255", {8'h00, c_hi, c_mid, c_lo}, 32'h00D55557);

    // mid-block clear, byte presented with clear is dropped
    stream(2, 8'h11, 1'b0, 1'b0, '0);  // full block first, then junk partial
    finish_block(model(2, 8'h11), "pre-clear");
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      valid = 1'b1;
      data  = 8'(i * 7 + 1);
    end
    @(negedge clk);
    clr = 1'b1; valid = 1'b1; data = 8'h5C;
    @(negedge clk);
    clr = 1'b0; valid = 1'b0;
    chk("R9", "clear keeps latched raw", 32'(raw), 32'(model(2, 8'h11)));
    chk("R9", "no done on clear", 32'(done), 32'd0);
    e = model(1, 8'h77);
    stream(1, 8'h77, 1'b0, 1'b0, '0);
    finish_block(e, "after clear R9");

    // back-to-back blocks
    e = model(4, 8'h0F);
    stream(4, 8'h0F, 1'b0, 1'b0, '0);
    stream(2, 8'hE1, 1'b1, 1'b1, e);
    finish_block(model(2, 8'hE1), "second b2b R8");

    // long idle with changing data
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      valid = 1'b0;
      data  = 8'(i * 37);
    end
    chk("R11", "raw held during idle", 32'(raw), 32'(model(2, 8'hE1)));
    chk("R10", "no done during idle", 32'(done), 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule